// File: doc/BRIEF.md
# Audio Stream Descriptor Register Bank

This block holds the programming state of one audio DMA stream: control, status, link position, cyclic buffer length, last valid index, FIFO watermark, FIFO size, sample format and the two halves of the buffer list base address. Software reaches it over a 32-bit register bus. The bus has a byte address and a 4-bit byte-enable. Each register applies its own read mask and write mask. Some written values are coerced to legal codes.

The block also sequences the stream. While the stream is running, only control and status may be written. Writes to any other register are dropped without an error. Setting the stream reset bit enters a reset state, and clearing it leaves that state. A RUN rising edge requests a fetch of the current buffer entry and enables the stream only once the fetch is acknowledged. The DMA engine consumes the 64-bit list base, the current entry index and the fetch/enable handshake. The engine supplies the link position, status events and the FIFO-ready level.

Top module: `sd_stream_regs`

## Requirements
- R1: Registers sit at dword-aligned positions selected by address bits [4:2]. The layout of each dword is as follows.
  - Dword 0: control in bytes 0–2, status in byte 3.
  - Dword 1: link position.
  - Dword 2: cyclic length.
  - Dword 3: last valid index in bits [15:0], watermark in bits [18:16].
  - Dword 4: FIFO size code in bits [7:0], format in bits [31:16].
  - Dword 6: base low.
  - Dword 7: base high.
  
  A write changes only the bytes whose enable is set. Dword 1 reads the `linkPos` input and cannot be written.
- R2: The writable control bits are 0x00F0001F. Control bits 0 and 1 change only through R4 and normal RUN writes. Format reads and writes through 0x7F7F. Base low keeps bits [31:7] only, so the base is 128-byte aligned.
- R3: While RUN (control bit 1) is 1, every write outside dword 0 is dropped, and the entry index is not cleared by it.
- R4: Control bit 0 set with RUN 0, outside reset, enters reset. A repeated set while in reset has no effect, and RUN cannot be set while in reset. Writing bit 0 as 0 leaves reset and reads back 0.
- R5: An accepted write to cyclic length, last valid index (bytes 0–1 of dword 3), base low or base high clears the entry index to 0 on the next cycle.
- R6: A RUN 0→1 transition raises `fetchReq` one cycle later. `streamEnable` rises only on the cycle after `fetchAck` is seen with `fetchReq` high. Clearing RUN drops both.
- R7: On an input stream, a watermark write of code 2, 3 or 4 is stored as written, and any other 3-bit value is stored as 4. On an output stream, watermark writes are ignored and the field reads 0.
- R8: FIFO size codes 0x0F, 0x1F, 0x3F, 0x7F, 0xBF and 0xFF are stored as written, and any other code is stored as 0xBF. `fifoBytes` equals the stored code plus one.
- R9: While `ctlrReset` is 1, every write is dropped.
- R10: `listBase` equals {base high, base low} on the cycle after either half is written.
- R11: Status bits 2–4 are set by `statusEvent[2:0]` and cleared by writing 1 to them, and a set wins over a same-cycle clear. Status bit 5 reads `fifoReady`.
- R12: While `streamEnable` is 1, each `entryNext` pulse advances the entry index, wrapping to 0 after it equals the last valid index.
- R13: After `rstN` or on entering stream reset, every register reads 0, except that control reads 0x01 while stream reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlrReset | input | 1 | Controller-wide reset held: blocks all writes |
| wrEn | input | 1 | Write strobe |
| addr | input | 5 | Byte address within the descriptor (read and write) |
| byteEn | input | 4 | Byte enables of the write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Masked read data for `addr` |
| linkPos | input | 32 | Current link position from the DMA engine |
| statusEvent | input | 3 | Sets status bits 2–4 |
| fifoReady | input | 1 | Reflected in status bit 5 |
| entryNext | input | 1 | Advance the buffer entry index |
| fetchAck | input | 1 | Buffer entry fetch finished |
| fetchReq | output | 1 | Fetch current buffer entry |
| streamEnable | output | 1 | Stream running after fetch |
| inReset | output | 1 | Stream reset state held |
| entryIdx | output | 8 | Current buffer entry index |
| listBase | output | 64 | Combined buffer list base |
| fifoBytes | output | 9 | Effective FIFO size in bytes |

## Verification
The bench builds two copies of the bank. One has `IS_INPUT=1` and one has `IS_INPUT=0`, and both use the default 8-bit entry index. The pair makes every watermark code reachable on both stream directions in one run. The FIFO size byte is narrow enough to sweep all 256 codes against the legal set. The 64 control byte-0 patterns that leave reset and RUN alone are also swept. With an index width of 8 and a last valid index of 2, the wrap of the entry index is reached within a few pulses.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int N_DW = 8;

  typedef struct packed {
    logic [N_DW-1:0] wrDw;   // one-hot accepted dword write
    logic byte0Ok;           // control byte 0 may be merged
    logic enterRst;
    logic exitRst;
    logic clrIdx;
    logic advance;
  } sd_strobe_t;

  function automatic logic [7:0] coerceFifo(input logic [7:0] code);
    case (code)
      8'h0F, 8'h1F, 8'h3F, 8'h7F, 8'hBF, 8'hFF: coerceFifo = code;
      default: coerceFifo = 8'hBF;
    endcase
  endfunction

  function automatic logic [2:0] coerceWm(input logic [2:0] code);
    coerceWm = (code >= 3'd2 && code <= 3'd4) ? code : 3'd4;
  endfunction

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldV, input logic [31:0] newV,
                                             input logic [3:0] be);
    for (int b = 0; b < 4; b++)
      mergeBytes[b*8 +: 8] = be[b] ? newV[b*8 +: 8] : oldV[b*8 +: 8];
  endfunction
endpackage

// File: rtl/sd_ctrl.sv
module sd_ctrl
  import sd_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlrReset,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        byteEn,
  input  logic [1:0]        wrCtlBits,
  input  logic              ctlRun,
  input  logic              entryNext,
  input  logic              fetchAck,
  output sd_strobe_t        strb,
  output logic              inReset,
  output logic              fetchReq,
  output logic              streamEnable
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] dwSel;
  logic accept, rstWr;
  logic inResetQ, runPrevQ, pendQ, enableQ;

  assign dwSel  = addr[ADDR_W-1:2];
  assign accept = wrEn && !ctlrReset && (dwSel == '0 || !ctlRun);
  assign rstWr  = accept && dwSel == '0 && byteEn[0];

  always_comb begin
    strb.wrDw     = accept ? (N_DW'(1) << dwSel) : '0;
    strb.byte0Ok  = !inResetQ;
    strb.enterRst = rstWr && wrCtlBits[0] && !wrCtlBits[1] && !ctlRun && !inResetQ;
    strb.exitRst  = rstWr && !wrCtlBits[0] && inResetQ;
    strb.clrIdx   = accept && (dwSel == SEL_W'(2) || dwSel == SEL_W'(6) || dwSel == SEL_W'(7) ||
                               (dwSel == SEL_W'(3) && |byteEn[1:0]));
    strb.advance  = entryNext && enableQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inResetQ <= 1'b0;
      runPrevQ <= 1'b0;
      pendQ    <= 1'b0;
      enableQ  <= 1'b0;
    end else begin
      if (strb.enterRst) inResetQ <= 1'b1;
      else if (strb.exitRst) inResetQ <= 1'b0;
      runPrevQ <= ctlRun;
      if (!ctlRun) begin
        pendQ   <= 1'b0;
        enableQ <= 1'b0;
      end else if (!runPrevQ) begin
        pendQ <= 1'b1;
      end else if (pendQ && fetchAck) begin
        pendQ   <= 1'b0;
        enableQ <= 1'b1;
      end
    end
  end

  assign inReset      = inResetQ;
  assign fetchReq     = pendQ;
  assign streamEnable = enableQ;

  assert_fetch_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enableQ) |-> $past(pendQ) && $past(fetchAck));
  assert_ctlr_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctlrReset |-> strb.wrDw == '0 && !strb.enterRst && !strb.exitRst);
  assert_no_nested_R4: assert property (@(posedge clk) disable iff (!rstN)
    inResetQ |-> !strb.enterRst);
  assert_run_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctlRun |-> (strb.wrDw & ~N_DW'(1)) == '0);
endmodule

// File: rtl/sd_regs.sv
module sd_regs
  import sd_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int IDX_W    = 8,
  parameter bit IS_INPUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sd_strobe_t        strb,
  input  logic [31:0]       wrData,
  input  logic [3:0]        byteEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       linkPos,
  input  logic [2:0]        statusEvent,
  input  logic              fifoReady,
  output logic [31:0]       rdData,
  output logic              ctlRun,
  output logic [63:0]       listBase,
  output logic [IDX_W-1:0]  entryIdx,
  output logic [8:0]        fifoBytes
);
  localparam logic [23:0] CTL_WMASK = 24'hF0001F;
  localparam logic [15:0] FMT_MASK  = 16'h7F7F;
  localparam logic [31:0] BASE_MASK = 32'hFFFFFF80;

  logic [23:0] ctlQ;
  logic [2:0]  stsQ, wmQ;
  logic [31:0] cblQ, baseLoQ, baseHiQ;
  logic [15:0] lviQ, fmtQ;
  logic [7:0]  fifoQ;
  logic [IDX_W-1:0] idxQ;
  logic [31:0] m0, m3, m4;
  logic [23:0] ctlW;
  logic [2:0]  w1c;

  assign m0 = mergeBytes({8'h0, ctlQ}, wrData, byteEn);
  assign m3 = mergeBytes({13'h0, wmQ, lviQ}, wrData, byteEn);
  assign m4 = mergeBytes({fmtQ, 8'h0, fifoQ}, wrData, byteEn);
  assign w1c = (strb.wrDw[0] && byteEn[3]) ? wrData[28:26] : 3'b0;

  always_comb begin
    ctlW    = m0[23:0] & CTL_WMASK;
    ctlW[0] = ctlQ[0];
    if (!strb.byte0Ok) ctlW[7:0] = ctlQ[7:0];
    if (strb.exitRst) ctlW[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.enterRst) begin
      ctlQ    <= (rstN && strb.enterRst) ? 24'h1 : 24'h0;
      stsQ    <= '0;
      cblQ    <= '0;
      lviQ    <= '0;
      wmQ     <= '0;
      fifoQ   <= '0;
      fmtQ    <= '0;
      baseLoQ <= '0;
      baseHiQ <= '0;
      idxQ    <= '0;
    end else begin
      if (strb.wrDw[0]) ctlQ <= ctlW;
      stsQ <= (stsQ & ~w1c) | statusEvent;
      if (strb.wrDw[2]) cblQ <= mergeBytes(cblQ, wrData, byteEn);
      if (strb.wrDw[3]) begin
        lviQ <= m3[15:0];
        if (IS_INPUT && byteEn[2]) wmQ <= coerceWm(wrData[18:16]);
      end
      if (strb.wrDw[4]) begin
        if (byteEn[0]) fifoQ <= coerceFifo(wrData[7:0]);
        fmtQ <= m4[31:16] & FMT_MASK;
      end
      if (strb.wrDw[6]) baseLoQ <= mergeBytes(baseLoQ, wrData, byteEn) & BASE_MASK;
      if (strb.wrDw[7]) baseHiQ <= mergeBytes(baseHiQ, wrData, byteEn);
      if (strb.clrIdx) idxQ <= '0;
      else if (strb.advance) idxQ <= (idxQ == lviQ[IDX_W-1:0]) ? '0 : idxQ + 1'b1;
    end
  end

  always_comb begin
    case (addr[ADDR_W-1:2])
      3'd0:    rdData = {2'b0, fifoReady, stsQ, 2'b0, ctlQ};
      3'd1:    rdData = linkPos;
      3'd2:    rdData = cblQ;
      3'd3:    rdData = {13'h0, wmQ, lviQ};
      3'd4:    rdData = {fmtQ, 8'h0, fifoQ};
      3'd6:    rdData = baseLoQ;
      3'd7:    rdData = baseHiQ;
      default: rdData = '0;
    endcase
  end

  assign ctlRun    = ctlQ[1];
  assign listBase  = {baseHiQ, baseLoQ};
  assign entryIdx  = idxQ;
  assign fifoBytes = {1'b0, fifoQ} + 9'd1;

  assert_base_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctlQ[1] |=> $stable(baseLoQ) && $stable(cblQ));
  assert_idx_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrIdx |=> idxQ == '0);
  assert_fifo_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    fifoQ != 8'h0 |-> fifoQ == coerceFifo(fifoQ));
  assert_wm_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    wmQ == 3'd0 || (wmQ >= 3'd2 && wmQ <= 3'd4));
  assert_sts_w1c_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDw[0] && byteEn[3] && wrData[26] && !statusEvent[0] && !strb.enterRst |=> !stsQ[0]);
endmodule

// File: rtl/sd_stream_regs.sv
module sd_stream_regs
  import sd_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int IDX_W    = 8,
  parameter bit IS_INPUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlrReset,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        byteEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [31:0]       linkPos,
  input  logic [2:0]        statusEvent,
  input  logic              fifoReady,
  input  logic              entryNext,
  input  logic              fetchAck,
  output logic              fetchReq,
  output logic              streamEnable,
  output logic              inReset,
  output logic [IDX_W-1:0]  entryIdx,
  output logic [63:0]       listBase,
  output logic [8:0]        fifoBytes
);
  sd_strobe_t strb;
  logic ctlRun;

  sd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlrReset(ctlrReset), .wrEn(wrEn), .addr(addr),
    .byteEn(byteEn), .wrCtlBits(wrData[1:0]), .ctlRun(ctlRun), .entryNext(entryNext),
    .fetchAck(fetchAck), .strb(strb), .inReset(inReset), .fetchReq(fetchReq),
    .streamEnable(streamEnable)
  );

  sd_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IS_INPUT(IS_INPUT)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .byteEn(byteEn), .addr(addr),
    .linkPos(linkPos), .statusEvent(statusEvent), .fifoReady(fifoReady), .rdData(rdData),
    .ctlRun(ctlRun), .listBase(listBase), .entryIdx(entryIdx), .fifoBytes(fifoBytes)
  );
endmodule

// File: tb/test_sd_stream_regs.sv
module test_sd_stream_regs;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, ctlrReset = 1'b0, wrEn = 1'b0;
  logic [4:0] addr = '0;
  logic [3:0] byteEn = '0;
  logic [31:0] wrData = '0, linkPos = 32'hCAFE0123;
  logic [2:0] statusEvent = '0;
  logic fifoReady = 1'b0, entryNext = 1'b0, fetchAck = 1'b0;
  logic [31:0] rdData, rdDataOut;
  logic fetchReq, streamEnable, inReset;
  logic [7:0] entryIdx;
  logic [63:0] listBase;
  logic [8:0] fifoBytes;
  logic fetchReqB, streamEnableB, inResetB;
  logic [7:0] entryIdxB;
  logic [63:0] listBaseB;
  logic [8:0] fifoBytesB;
  int checks = 0, failures = 0;

  always #(PERIOD/2) clk = ~clk;

  sd_stream_regs #(.IS_INPUT(1'b1)) i_sd_stream_regs (
    .clk(clk), .rstN(rstN), .ctlrReset(ctlrReset), .wrEn(wrEn), .addr(addr), .byteEn(byteEn),
    .wrData(wrData), .rdData(rdData), .linkPos(linkPos), .statusEvent(statusEvent),
    .fifoReady(fifoReady), .entryNext(entryNext), .fetchAck(fetchAck), .fetchReq(fetchReq),
    .streamEnable(streamEnable), .inReset(inReset), .entryIdx(entryIdx), .listBase(listBase),
    .fifoBytes(fifoBytes));

  sd_stream_regs #(.IS_INPUT(1'b0)) i_sd_stream_regs_out (
    .clk(clk), .rstN(rstN), .ctlrReset(ctlrReset), .wrEn(wrEn), .addr(addr), .byteEn(byteEn),
    .wrData(wrData), .rdData(rdDataOut), .linkPos(linkPos), .statusEvent(statusEvent),
    .fifoReady(fifoReady), .entryNext(entryNext), .fetchAck(fetchAck), .fetchReq(fetchReqB),
    .streamEnable(streamEnableB), .inReset(inResetB), .entryIdx(entryIdxB), .listBase(listBaseB),
    .fifoBytes(fifoBytesB));

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    addr = a; wrData = d; byteEn = be; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; byteEn = '0;
  endtask

  task automatic rd(input logic [4:0] a);
    addr = a;
    #1;
  endtask

  function automatic logic [7:0] expFifo(input int c);
    if (c == 8'h0F || c == 8'h1F || c == 8'h3F || c == 8'h7F || c == 8'hBF || c == 8'hFF)
      return 8'(c);
    return 8'hBF;
  endfunction

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] expIdx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    rd(5'h00); check("R13 ctl/sts", rdData, 0);
    rd(5'h08); check("R13 cbl", rdData, 0);
    check("R13 listBase", listBase, 0);
    check("R13 fetch/en/rst", {fetchReq, streamEnable, inReset}, 0);
    // R1 link position read-only, sub-word writes
    wr(5'h04, 32'h12345678, 4'hF);
    rd(5'h04); check("R1 linkPos", rdData, 32'hCAFE0123);
    wr(5'h08, 32'h11223344, 4'hF);
    wr(5'h08, 32'h00AA0000, 4'b0100);
    rd(5'h08); check("R1 byte merge", rdData, 32'h11AA3344);
    // R2 masks
    wr(5'h00, 32'hFFFFFFFC, 4'b0111);
    rd(5'h00); check("R2 ctl mask", rdData, 32'h00F0001C);
    for (int v = 0; v < 256; v += 4) begin
      wr(5'h00, 32'(v), 4'b0001);
      rd(5'h00); check("R2 ctl byte0 sweep", rdData, 32'h00F00000 | (32'(v) & 32'h1C));
    end
    wr(5'h00, 32'h0, 4'b0111);
    wr(5'h10, 32'hFFFF0000, 4'b1100);
    rd(5'h10); check("R2 fmt mask", rdData[31:16], 16'h7F7F);
    wr(5'h18, 32'h9ABCDEFF, 4'hF);
    rd(5'h18); check("R2 base align", rdData, 32'h9ABCDE80);
    // R10 list base
    wr(5'h1C, 32'h12345678, 4'hF);
    check("R10 listBase", listBase, 64'h123456789ABCDE80);
    // R8 fifo sweep
    for (int c = 0; c < 256; c++) begin
      wr(5'h10, 32'(c), 4'b0001);
      rd(5'h10); check("R8 fifo code", rdData[7:0], expFifo(c));
      check("R8 fifo bytes", fifoBytes, {1'b0, expFifo(c)} + 9'd1);
    end
    // R7 watermark both directions
    for (int w = 0; w < 8; w++) begin
      wr(5'h0C, 32'(w) << 16, 4'b0100);
      rd(5'h0C);
      check("R7 wm input", rdData[18:16], (w >= 2 && w <= 4) ? 3'(w) : 3'd4);
      check("R7 wm output", rdDataOut[18:16], 3'd0);
    end
    // R11 status
    @(negedge clk); statusEvent = 3'b101;
    @(negedge clk); statusEvent = 3'b000;
    rd(5'h00); check("R11 sts set", rdData[31:24], 8'h14);
    wr(5'h00, 32'h04000000, 4'b1000);
    rd(5'h00); check("R11 sts w1c", rdData[31:24], 8'h10);
    fifoReady = 1'b1;
    rd(5'h00); check("R11 fifo ready", rdData[31:24], 8'h30);
    // R6 fetch then enable, R12 advance
    wr(5'h0C, 32'h0002, 4'b0011);
    wr(5'h00, 32'h02, 4'b0001);
    check("R6 no req yet", {fetchReq, streamEnable}, 2'b00);
    @(negedge clk);
    check("R6 req", {fetchReq, streamEnable}, 2'b10);
    @(negedge clk);
    check("R6 wait ack", {fetchReq, streamEnable}, 2'b10);
    fetchAck = 1'b1;
    @(negedge clk); fetchAck = 1'b0;
    check("R6 enabled", {fetchReq, streamEnable}, 2'b01);
    expIdx = 0;
    entryNext = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      expIdx = (expIdx == 8'd2) ? 8'd0 : expIdx + 8'd1;
      check("R12 advance", entryIdx, expIdx);
    end
    entryNext = 1'b0;
    // R3 run freeze
    wr(5'h08, 32'h0, 4'hF);
    rd(5'h08); check("R3 cbl frozen", rdData, 32'h11AA3344);
    check("R3 idx kept", entryIdx, 8'd1);
    @(negedge clk); statusEvent = 3'b100;
    @(negedge clk); statusEvent = 3'b000;
    wr(5'h00, 32'h10000000, 4'b1000);
    rd(5'h00); check("R3 sts write in run", rdData[31:24], 8'h20);
    // stop run, then R5
    wr(5'h00, 32'h0, 4'b0001);
    @(negedge clk);
    check("R6 run off", {fetchReq, streamEnable}, 2'b00);
    check("R5 idx before", entryIdx, 8'd1);
    wr(5'h0C, 32'h0003, 4'b0001);
    check("R5 idx cleared", entryIdx, 8'd0);
    // R9
    ctlrReset = 1'b1;
    wr(5'h08, 32'h55, 4'hF);
    wr(5'h00, 32'h01, 4'b0001);
    ctlrReset = 1'b0;
    rd(5'h08); check("R9 blocked", rdData, 32'h11AA3344);
    check("R9 no reset", inReset, 1'b0);
    // R4 / R13 stream reset
    wr(5'h00, 32'h01, 4'b0001);
    check("R4 enter", inReset, 1'b1);
    rd(5'h00); check("R13 ctl in reset", rdData[23:0], 24'h1);
    rd(5'h08); check("R13 cbl cleared", rdData, 0);
    check("R13 base cleared", listBase, 0);
    wr(5'h08, 32'h77, 4'hF);
    wr(5'h00, 32'h01, 4'b0001);
    rd(5'h08); check("R4 nested no clear", rdData, 32'h77);
    wr(5'h00, 32'h03, 4'b0001);
    rd(5'h00); check("R4 no run in reset", rdData[23:0], 24'h1);
    wr(5'h00, 32'h00, 4'b0001);
    check("R4 exit", inReset, 1'b0);
    rd(5'h00); check("R4 bit cleared", rdData[23:0], 24'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule